// File: doc/BRIEF.md
# Multi-Mode Programmable Counter-Timer Channel

This block is one channel of a 16-bit down-counting counter-timer. It runs on a fast system clock. It watches a slower timer clock input and acts on each falling edge of that input. A gate input, with a selectable active level, decides whether those edges are counted. Software fills a 16-bit preload register one byte at a time, in either order. It then writes an 8-bit control word that picks an operating mode, the gate level, run or halt, event enable, and freezing of the readback register.

The count does not start when software writes it. The counter takes the preload value on the first counted timer-clock edge after a mode is selected, and later counted edges decrement it. Depending on the mode, reaching zero does one of the following:
- sets the output permanently,
- emits a strobe one timer clock wide,
- reloads for a periodic pulse,
- toggles between two programmed phase lengths.

A retriggerable gated one-shot is also available. The true output and its complement drive external logic. A one-cycle timeout event and an enabled copy of it feed the interrupt logic of the surrounding chip. A 16-bit holding register follows the counter for readback and can be frozen so that two byte reads give one consistent value.

Top module: `cntr_timer_chan`

## Requirements
- R1: After reset, out_true is 0, out_comp is 1, hold_q is 0 and neither tmo_evt nor irq_evt pulses.
- R2: jam_wr_lo writes jam_byte into preload bits 7..0 and jam_wr_hi writes it into bits 15..8, in either order. The counter takes the preload value on the first falling timer-clock edge that arrives with run set and the gate valid after a mode write.
- R3: A falling timer-clock edge changes the counter only while run (control bit 5) is 1 and the gate is valid. Control bit 4 set to 1 makes gate_in valid when high; set to 0, it makes gate_in valid when low.
- R4: Writing a control word with a valid mode code forces out_true to 0 and out_comp to 1. The valid codes in bits 2..0 are:
  - 001: timeout
  - 010: strobe
  - 011 with bit 7 = 0: one-shot
  - 100: rate generator
  - 101 and 111: duty cycle
- R5: In timeout mode with preload N, out_true goes to 1 on the N-th counted edge after the load edge and stays there. tmo_evt pulses for exactly one system cycle at that point.
- R6: In strobe mode, out_true is 1 only from the N-th counted edge after the load edge until the next timer-clock edge, and then stays 0.
- R7: In rate-generator mode, out_true is 1 for one timer clock on every N-th counted edge after the load edge, and tmo_evt pulses at each of them.
- R8: In duty-cycle mode, out_true is high for H timer clocks and then low for L timer clocks, repeating. H is preload bits 15..8 and L is bits 7..0. The high phase starts at the load edge.
- R9: In one-shot mode, a rise of the gate to its valid level before timeout reloads the counter from the preload register on the next counted edge. out_true goes to 1 N counted edges after that reload.
- R10: While control bit 6 is 1, hold_q keeps its value and the counter keeps counting. While bit 6 is 0, hold_q follows the counter one system cycle later.
- R11: Control codes 000, 110, and 011 with bit 7 = 1 leave out_true, the counter and the active mode unchanged. The remaining control fields still take the new values.
- R12: irq_evt equals tmo_evt while control bit 3 is 1, and stays 0 while bit 3 is 0.
- R13: In duty-cycle mode, a phase byte of 0 gives a phase of 256 timer clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tclk_in | input | 1 | Timer clock input; its falling edge advances the channel |
| gate_in | input | 1 | Gate input, with the active level set by control bit 4 |
| jam_wr_hi | input | 1 | Write strobe for the preload high byte |
| jam_wr_lo | input | 1 | Write strobe for the preload low byte |
| jam_byte | input | 8 | Preload byte data |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_byte | input | 8 | Control word |
| out_true | output | 1 | True timer output |
| out_comp | output | 1 | Complementary timer output |
| tmo_evt | output | 1 | One-cycle pulse when the count reaches zero |
| irq_evt | output | 1 | tmo_evt qualified by the event enable bit |
| hold_q | output | 16 | Holding register for counter readback |

## Verification
The hardest state to reach from the ports is a retrigger in one-shot mode. It needs a count already in progress, then the gate taken invalid and made valid again before zero, and only then the next counted edge. The stimulus loads a preload value, counts part of it, and drops the gate across a timer-clock edge to show that the edge is ignored. It then raises the gate and confirms that hold_q jumps back to the full preload value. It then counts the full N edges to the output change. The 256-clock duty phase for a zero byte is driven by a long run of timer-clock edges, sampled just before, at and just after the phase boundary. Random preload values in timeout mode check the readback on every step.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

    localparam int CTL_W    = 8;
    localparam int IEN_BIT  = 3;
    localparam int GLVL_BIT = 4;
    localparam int RUN_BIT  = 5;
    localparam int FRZ_BIT  = 6;
    localparam int EXT_BIT  = 7;

    typedef enum logic [2:0] {
        MD_NONE = 3'd0,
        MD_TMO  = 3'd1,
        MD_STB  = 3'd2,
        MD_ONE  = 3'd3,
        MD_RATE = 3'd4,
        MD_DUTY = 3'd5
    } mode_e;

    typedef struct packed {
        logic frz;
        logic run;
        logic glvl;
        logic ien;
    } cfg_t;

    // Map the 3-bit mode field (plus the extension bit) to an operating mode.
    function automatic mode_e decode_mode(input logic [CTL_W-1:0] w);
        mode_e m;
        case (w[2:0])
            3'b001:         m = MD_TMO;
            3'b010:         m = MD_STB;
            3'b011:         m = w[EXT_BIT] ? MD_NONE : MD_ONE;
            3'b100:         m = MD_RATE;
            3'b101, 3'b111: m = MD_DUTY;
            default:        m = MD_NONE;
        endcase
        return m;
    endfunction

    function automatic cfg_t decode_cfg(input logic [CTL_W-1:0] w);
        cfg_t c;
        c.frz  = w[FRZ_BIT];
        c.run  = w[RUN_BIT];
        c.glvl = w[GLVL_BIT];
        c.ien  = w[IEN_BIT];
        return c;
    endfunction

    // Modes whose output pulse lasts one timer clock.
    function automatic logic is_pulse_mode(input mode_e m);
        return (m == MD_STB) || (m == MD_RATE);
    endfunction

endpackage

// File: rtl/ctc_edge.sv
module ctc_edge #(
    parameter bit RISE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic edge_o
);
    logic sig_r;

    always_ff @(posedge clk) begin
        if (rst) sig_r <= 1'b0;
        else     sig_r <= sig;
    end

    generate
        if (RISE) begin : g_rise
            assign edge_o = sig & ~sig_r;
        end else begin : g_fall
            assign edge_o = ~sig & sig_r;
        end
    endgenerate
endmodule

// File: rtl/ctc_regs.sv
module ctc_regs
    import ctc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = CNT_W / 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                jam_wr_hi,
    input  logic                jam_wr_lo,
    input  logic [BYTE_W-1:0]   jam_byte,
    input  logic                ctl_wr,
    input  logic [CTL_W-1:0]    ctl_byte,
    output logic [CNT_W-1:0]    jam_q,
    output cfg_t                cfg_q,
    output mode_e               mode_q,
    output logic                mode_load
);
    mode_e wr_mode;

    assign wr_mode   = decode_mode(ctl_byte);
    assign mode_load = ctl_wr && (wr_mode != MD_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            jam_q <= '0;
        end else begin
            if (jam_wr_lo) jam_q[BYTE_W-1:0]     <= jam_byte;
            if (jam_wr_hi) jam_q[CNT_W-1:BYTE_W] <= jam_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            mode_q <= MD_NONE;
        end else if (ctl_wr) begin
            cfg_q <= decode_cfg(ctl_byte);
            if (mode_load) mode_q <= wr_mode;
        end
    end
endmodule

// File: rtl/ctc_core.sv
module ctc_core
    import ctc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              gate_ok,
    input  logic              gate_rise,
    input  logic              run,
    input  mode_e             mode_q,
    input  logic              mode_load,
    input  logic [CNT_W-1:0]  jam_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              out_q,
    output logic              evt_q
);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);
    localparam int               PAD_W = CNT_W - BYTE_W - 1;

    logic armed_q;
    logic done_q;
    logic phase_hi_q;
    logic step;

    // A zero phase byte stands for a full 2**BYTE_W clocks.
    function automatic logic [CNT_W-1:0] phase_len(input logic [BYTE_W-1:0] b);
        return {{PAD_W{1'b0}}, (b == '0), b};
    endfunction

    assign step = tick && run && gate_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            out_q      <= 1'b0;
            evt_q      <= 1'b0;
            armed_q    <= 1'b0;
            done_q     <= 1'b0;
            phase_hi_q <= 1'b0;
        end else begin
            evt_q <= 1'b0;
            if (mode_load) begin
                armed_q    <= 1'b1;
                done_q     <= 1'b0;
                out_q      <= 1'b0;
                phase_hi_q <= 1'b0;
            end else if (mode_q != MD_NONE) begin
                if (tick && out_q && is_pulse_mode(mode_q)) out_q <= 1'b0;
                if (step) begin
                    if (armed_q) begin
                        armed_q <= 1'b0;
                        if (mode_q == MD_DUTY) begin
                            cnt_q      <= phase_len(jam_q[CNT_W-1:BYTE_W]);
                            out_q      <= 1'b1;
                            phase_hi_q <= 1'b1;
                        end else begin
                            cnt_q <= jam_q;
                        end
                    end else if (!done_q) begin
                        if (cnt_q == ONE_C) begin
                            evt_q <= 1'b1;
                            case (mode_q)
                                MD_RATE: begin
                                    out_q <= 1'b1;
                                    cnt_q <= jam_q;
                                end
                                MD_DUTY: begin
                                    phase_hi_q <= ~phase_hi_q;
                                    out_q      <= ~phase_hi_q;
                                    cnt_q      <= phase_hi_q ?
                                                  phase_len(jam_q[BYTE_W-1:0]) :
                                                  phase_len(jam_q[CNT_W-1:BYTE_W]);
                                end
                                default: begin
                                    out_q  <= 1'b1;
                                    done_q <= 1'b1;
                                    cnt_q  <= '0;
                                end
                            endcase
                        end else begin
                            cnt_q <= cnt_q - ONE_C;
                        end
                    end
                end
                if (mode_q == MD_ONE && !done_q && run && gate_rise) armed_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ctc_hold.sv
module ctc_hold #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frz,
    input  logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] hold_q
);
    always_ff @(posedge clk) begin
        if (rst)       hold_q <= '0;
        else if (!frz) hold_q <= cnt_q;
    end
endmodule

// File: rtl/cntr_timer_chan.sv
module cntr_timer_chan
    import ctc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tclk_in,
    input  logic                 gate_in,
    input  logic                 jam_wr_hi,
    input  logic                 jam_wr_lo,
    input  logic [CNT_W/2-1:0]   jam_byte,
    input  logic                 ctl_wr,
    input  logic [7:0]           ctl_byte,
    output logic                 out_true,
    output logic                 out_comp,
    output logic                 tmo_evt,
    output logic                 irq_evt,
    output logic [CNT_W-1:0]     hold_q
);
    localparam int BYTE_W = CNT_W / 2;

    logic [CNT_W-1:0] jam_q;
    logic [CNT_W-1:0] cnt_q;
    cfg_t             cfg_q;
    mode_e            mode_q;
    logic             mode_load;
    logic             tick;
    logic             gate_ok;
    logic             gate_rise;
    logic             out_q;
    logic             evt_q;
    logic             cfg_frz;
    logic             cfg_run;

    assign gate_ok = ~(gate_in ^ cfg_q.glvl);
    assign cfg_frz = cfg_q.frz;
    assign cfg_run = cfg_q.run;

    ctc_edge #(.RISE(1'b0)) u_tclk_edge (
        .clk(clk), .rst(rst), .sig(tclk_in), .edge_o(tick)
    );

    ctc_edge #(.RISE(1'b1)) u_gate_edge (
        .clk(clk), .rst(rst), .sig(gate_ok), .edge_o(gate_rise)
    );

    ctc_regs #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst(rst),
        .jam_wr_hi(jam_wr_hi), .jam_wr_lo(jam_wr_lo), .jam_byte(jam_byte),
        .ctl_wr(ctl_wr), .ctl_byte(ctl_byte),
        .jam_q(jam_q), .cfg_q(cfg_q), .mode_q(mode_q), .mode_load(mode_load)
    );

    ctc_core #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_core (
        .clk(clk), .rst(rst), .tick(tick), .gate_ok(gate_ok),
        .gate_rise(gate_rise), .run(cfg_q.run), .mode_q(mode_q),
        .mode_load(mode_load), .jam_q(jam_q),
        .cnt_q(cnt_q), .out_q(out_q), .evt_q(evt_q)
    );

    ctc_hold #(.CNT_W(CNT_W)) u_hold (
        .clk(clk), .rst(rst), .frz(cfg_q.frz), .cnt_q(cnt_q), .hold_q(hold_q)
    );

    assign out_true = out_q;
    assign out_comp = ~out_q;
    assign tmo_evt  = evt_q;
    assign irq_evt  = evt_q & cfg_q.ien;
endmodule

// File: rtl/ctc_chk.sv
module ctc_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             ctl_wr,
    input logic [7:0]       ctl_byte,
    input logic             out_true,
    input logic             tmo_evt,
    input logic             irq_evt,
    input logic [CNT_W-1:0] hold_q,
    input logic             cfg_frz,
    input logic             cfg_run
);
    logic valid_code;
    assign valid_code = (ctl_byte[2:0] != 3'b000) && (ctl_byte[2:0] != 3'b110) &&
                        !(ctl_byte[2:0] == 3'b011 && ctl_byte[7]);

    // R4
    mode_write_clears_out_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && valid_code) |=> !out_true);

    // R5
    evt_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        tmo_evt |=> !tmo_evt);

    // R12
    irq_needs_evt_chk: assert property (@(posedge clk) disable iff (rst)
        irq_evt |-> tmo_evt);

    // R10
    frozen_hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_frz |=> $stable(hold_q));

    // R3
    halted_no_evt_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_run |=> !tmo_evt);
endmodule

bind cntr_timer_chan ctc_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_byte(ctl_byte),
    .out_true(out_true), .tmo_evt(tmo_evt), .irq_evt(irq_evt),
    .hold_q(hold_q), .cfg_frz(cfg_frz), .cfg_run(cfg_run)
);

// File: tb/sim_cntr_timer_chan.sv
`timescale 1ns/1ps
module sim_cntr_timer_chan;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tclk_in = 1'b0;
    logic        gate_in = 1'b1;
    logic        jam_wr_hi = 1'b0;
    logic        jam_wr_lo = 1'b0;
    logic [7:0]  jam_byte = '0;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_byte = '0;
    logic        out_true, out_comp, tmo_evt, irq_evt;
    logic [15:0] hold_q;

    int checks = 0;
    int failures = 0;
    logic s_evt, s_irq, s_out;

    always #2.5 clk = ~clk;

    cntr_timer_chan u0 (
        .clk(clk), .rst(rst), .tclk_in(tclk_in), .gate_in(gate_in),
        .jam_wr_hi(jam_wr_hi), .jam_wr_lo(jam_wr_lo), .jam_byte(jam_byte),
        .ctl_wr(ctl_wr), .ctl_byte(ctl_byte),
        .out_true(out_true), .out_comp(out_comp), .tmo_evt(tmo_evt),
        .irq_evt(irq_evt), .hold_q(hold_q)
    );

    // control word: bit6 freeze, bit5 run, bit4 gate level, bit3 enable, bits2..0 mode
    function automatic logic [7:0] cw(input logic [2:0] m, input logic ien,
                                      input logic glvl, input logic run, input logic frz);
        return {1'b0, frz, run, glvl, ien, m};
    endfunction

    // expected duty-cycle output at sample i after the load edge
    function automatic logic exp_duty(input int h, input int l, input int i);
        return (i % (h + l)) < h;
    endfunction

    function automatic int exp_tmo_hold(input int n, input int k);
        return (k < n) ? n - k : 0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_jam(input logic [15:0] v, input logic hi_first);
        @(negedge clk);
        jam_byte = hi_first ? v[15:8] : v[7:0];
        jam_wr_hi = hi_first; jam_wr_lo = !hi_first;
        @(negedge clk);
        jam_byte = hi_first ? v[7:0] : v[15:8];
        jam_wr_hi = !hi_first; jam_wr_lo = hi_first;
        @(negedge clk);
        jam_wr_hi = 1'b0; jam_wr_lo = 1'b0;
    endtask

    task automatic wr_ctl(input logic [7:0] b);
        @(negedge clk); ctl_wr = 1'b1; ctl_byte = b;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); tclk_in = 1'b1;
        @(negedge clk); tclk_in = 1'b0;
        @(negedge clk);
        s_evt = tmo_evt; s_irq = irq_evt; s_out = out_true;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL WATCHDOG act=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 out_true", out_true, 0);
        chk("R1 out_comp", out_comp, 1);
        chk("R1 hold", hold_q, 0);
        chk("R1 evt", tmo_evt | irq_evt, 0);

        // R2 low byte first, R5 timeout, R12 enabled event
        wr_jam(16'd5, 1'b0);
        wr_ctl(cw(3'b001, 1, 1, 1, 0));
        chk("R4 out low", out_true, 0);
        chk("R4 comp high", out_comp, 1);
        tick();
        chk("R2 load", hold_q, 5);
        for (int k = 1; k <= 6; k++) begin
            tick();
            if (k < 5) chk("R5 count", hold_q, 5 - k);
            chk("R5 out", s_out, k >= 5);
            chk("R5 evt", s_evt, k == 5);
            chk("R12 irq", s_irq, k == 5);
        end

        // R3 halted, then gate polarity; R2 high byte first
        wr_jam(16'h0103, 1'b1);
        wr_ctl(cw(3'b001, 1, 1, 0, 0));
        tick(); tick();
        chk("R3 halted", hold_q, 0);
        wr_ctl(cw(3'b000, 1, 1, 1, 0));
        chk("R11 noop out", out_true, 0);
        tick();
        chk("R2 hi first", hold_q, 16'h0103);
        wr_ctl(cw(3'b000, 1, 0, 1, 0));
        tick(); tick();
        chk("R3 gate invalid", hold_q, 16'h0103);
        gate_in = 1'b0;
        tick();
        chk("R3 active low", hold_q, 16'h0102);
        gate_in = 1'b1;
        wr_ctl(cw(3'b000, 1, 1, 1, 0));

        // R12 disabled, R11 no-op codes
        wr_jam(16'd2, 1'b0);
        wr_ctl(cw(3'b001, 0, 1, 1, 0));
        tick(); tick(); tick();
        chk("R5 out", s_out, 1);
        chk("R12 evt", s_evt, 1);
        chk("R12 irq off", s_irq, 0);
        wr_ctl(cw(3'b000, 0, 1, 1, 0));
        chk("R11 code000", out_true, 1);
        wr_ctl(cw(3'b110, 0, 1, 1, 0));
        chk("R11 code110", out_true, 1);
        wr_ctl(8'b1011_0011);
        chk("R11 code011x", out_true, 1);
        tick();
        chk("R11 counter", hold_q, 0);
        chk("R11 mode kept", s_out, 1);

        // R6 strobe
        wr_jam(16'd3, 1'b0);
        wr_ctl(cw(3'b010, 1, 1, 1, 0));
        tick();
        for (int k = 1; k <= 5; k++) begin
            tick();
            chk("R6 strobe", s_out, k == 3);
        end

        // R7 rate generator
        wr_ctl(cw(3'b100, 1, 1, 1, 0));
        tick();
        for (int k = 1; k <= 9; k++) begin
            tick();
            chk("R7 rate out", s_out, (k % 3) == 0);
            chk("R7 rate evt", s_evt, (k % 3) == 0);
        end

        // R8 duty with code 101 and 111
        wr_jam({8'd2, 8'd3}, 1'b0);
        wr_ctl(cw(3'b101, 1, 1, 1, 0));
        for (int i = 0; i < 12; i++) begin
            tick();
            chk("R8 duty", s_out, exp_duty(2, 3, i));
        end
        wr_jam({8'd1, 8'd2}, 1'b1);
        wr_ctl(cw(3'b111, 1, 1, 1, 0));
        chk("R4 code111 low", out_true, 0);
        for (int i = 0; i < 7; i++) begin
            tick();
            chk("R8 code111", s_out, exp_duty(1, 2, i));
        end

        // R13 zero phase byte
        wr_jam({8'd0, 8'd1}, 1'b0);
        wr_ctl(cw(3'b101, 1, 1, 1, 0));
        for (int i = 0; i <= 257; i++) begin
            tick();
            if (i >= 255) chk("R13 long phase", s_out, exp_duty(256, 1, i));
        end

        // R9 retriggered one-shot
        wr_jam(16'd4, 1'b0);
        wr_ctl(cw(3'b011, 1, 1, 1, 0));
        tick();
        chk("R9 load", hold_q, 4);
        tick(); tick();
        chk("R9 partial", hold_q, 2);
        gate_in = 1'b0;
        tick();
        chk("R3 gate low ignored", hold_q, 2);
        gate_in = 1'b1;
        tick();
        chk("R9 reload", hold_q, 4);
        for (int k = 1; k <= 4; k++) begin
            tick();
            chk("R9 out", s_out, k == 4);
        end

        // R10 freeze
        wr_jam(16'd10, 1'b0);
        wr_ctl(cw(3'b001, 1, 1, 1, 0));
        tick(); tick();
        chk("R10 follow", hold_q, 9);
        wr_ctl(cw(3'b000, 1, 1, 1, 1));
        tick(); tick();
        chk("R10 frozen", hold_q, 9);
        wr_ctl(cw(3'b000, 1, 1, 1, 0));
        @(negedge clk);
        chk("R10 kept counting", hold_q, 7);

        // R5 random preload values
        for (int r = 0; r < 8; r++) begin
            n = 2 + int'($urandom % 29);
            wr_jam(16'(n), r[0]);
            wr_ctl(cw(3'b001, 1, 1, 1, 0));
            tick();
            chk("R2 rand load", hold_q, n);
            for (int k = 1; k <= n; k++) begin
                tick();
                chk("R5 rand hold", hold_q, exp_tmo_hold(n, k));
                chk("R5 rand out", s_out, k >= n);
                chk("R5 rand evt", s_evt, k == n);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule